// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupts

A 32-pin general-purpose I/O port that sits on a simple memory-mapped register bus. It has one 32-bit word per register. The host sets an output value and a per-pin output enable. It can read back the synchronized level of every pad, whichever way the pad is driven. Every pin also has its own interrupt trigger. The host picks one of four conditions for each pin: low level, high level, rising edge or falling edge.

A pin that meets its condition sets its bit in a sticky event register. The host clears that register by writing ones. An enable register gates the event bits. The gated events for pins 0 to 15 drive one interrupt line, and the gated events for pins 16 to 31 drive a second line. A third line is the OR of the two.

A build-time parameter picks one of two register placements. The same parameter picks one of two trigger-code maps. Emulating both-edge triggering is left to host software: on each event the host swaps the pin between the low-level and high-level codes.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is held, every register reads zero and all outputs are zero: `pad_out`, `pad_oe`, `irq_lo`, `irq_hi` and `irq_any`.
- R2: `pad_out` equals the output-value register and `pad_oe` equals the output-enable register. A 1 in the enable register drives that pin. Both registers read back what was written.
- R3: The pad-level register returns `pad_in` after a two-flop synchronizer. A change at the pins becomes visible after the second clock edge and not after the first. The level is reported whatever the pin's direction.
- R4: The trigger code for pin n is 2 bits wide. Pins 0 to 15 take their code from the low config register and pins 16 to 31 from the high config register. In each register, pin n's code sits at bits [2*(n mod 16)+1 : 2*(n mod 16)]. With ALT_MAP=0, the codes are: 0 low level, 1 high level, 2 rising edge, 3 falling edge.
- R5: An edge is a difference between two consecutive synchronized samples. A pin coded for rising edge sets its event bit on 0 to 1 only. A pin coded for falling edge sets it on 1 to 0 only. The event bit is set three clock edges after the pin change.
- R6: A pin coded for a level sets its event bit on every cycle the level holds. If a hardware set and a clearing write hit the same bit in the same cycle, the bit stays set. Once the level goes away, a clear takes effect.
- R7: Writing the event register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R8: `irq_lo` is high when any pin 0 to 15 has both its event bit and its enable bit set. `irq_hi` does the same for pins 16 to 31. `irq_any` is the OR of the two. With the enable register at zero, all three are low.
- R9: With ALT_MAP=0, the offsets are: value 0x00, enable 0x04, level 0x08, config low 0x0C, config high 0x10, gate 0x14, event 0x18. With ALT_MAP=1, they are: enable 0x00, value 0x1C, level 0x24, config 0x28/0x2C, gate 0x30, event 0x34. With ALT_MAP=1 the codes are 0 rising, 1 falling, 2 high level, 3 low level.
- R10: A read from an offset that the chosen placement does not use returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Levels sensed at the pins |
| pad_out | output | 32 | Value to drive onto the pins |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Interrupt for pins 0 to 15 |
| irq_hi | output | 1 | Interrupt for pins 16 to 31 |
| irq_any | output | 1 | OR of both interrupt lines |

## Verification
The trigger logic is driven by one pad change that moves several pins at once. One pin rises, one falls and one rises in the upper half. The rising-only event word shows that the edge polarity is decoded and that untouched pins stay quiet. A single pin is then switched to falling edge, which shows where its field sits in the config register. A high-level pin is cleared while its level is still present, and again after the level is gone; this tells a sticky level trigger apart from a one-shot edge. The gate register is stepped through a low-half bit, a high-half bit and zero, which shows the split of the interrupt lines. The alternate instance starts from reset with pads low: its event word stays zero under code 0, where the default map would set every bit, so the code map is visible.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int OFFS_W = 8;

    typedef enum logic [1:0] {
        TRIG_LOW,
        TRIG_HIGH,
        TRIG_RISE,
        TRIG_FALL
    } trig_e;

    typedef enum logic [2:0] {
        SEL_VALUE,
        SEL_ENABLE,
        SEL_LEVEL,
        SEL_CFG_LO,
        SEL_CFG_HI,
        SEL_GATE,
        SEL_EVENT,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [OFFS_W-1:0] value;
        logic [OFFS_W-1:0] enable;
        logic [OFFS_W-1:0] level;
        logic [OFFS_W-1:0] cfg_lo;
        logic [OFFS_W-1:0] cfg_hi;
        logic [OFFS_W-1:0] gate;
        logic [OFFS_W-1:0] event_w;
    } layout_t;

    function automatic layout_t layout_for(input logic alt);
        layout_t l;
        if (alt) begin
            l.enable  = 8'h00;
            l.value   = 8'h1C;
            l.level   = 8'h24;
            l.cfg_lo  = 8'h28;
            l.cfg_hi  = 8'h2C;
            l.gate    = 8'h30;
            l.event_w = 8'h34;
        end else begin
            l.value   = 8'h00;
            l.enable  = 8'h04;
            l.level   = 8'h08;
            l.cfg_lo  = 8'h0C;
            l.cfg_hi  = 8'h10;
            l.gate    = 8'h14;
            l.event_w = 8'h18;
        end
        return l;
    endfunction

    function automatic reg_sel_e decode_offset(input logic [OFFS_W-1:0] a, input layout_t l);
        reg_sel_e s;
        s = SEL_NONE;
        if (a == l.value)   s = SEL_VALUE;
        if (a == l.enable)  s = SEL_ENABLE;
        if (a == l.level)   s = SEL_LEVEL;
        if (a == l.cfg_lo)  s = SEL_CFG_LO;
        if (a == l.cfg_hi)  s = SEL_CFG_HI;
        if (a == l.gate)    s = SEL_GATE;
        if (a == l.event_w) s = SEL_EVENT;
        return s;
    endfunction

    function automatic trig_e map_code(input logic alt, input logic [1:0] c);
        trig_e t;
        if (!alt) begin
            t = trig_e'(c);
        end else begin
            case (c)
                2'd0:    t = TRIG_RISE;
                2'd1:    t = TRIG_FALL;
                2'd2:    t = TRIG_HIGH;
                default: t = TRIG_LOW;
            endcase
        end
        return t;
    endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            stable_q <= '0;
            prev_q   <= '0;
        end else begin
            meta_q   <= pad_in;
            stable_q <= meta_q;
            prev_q   <= stable_q;
        end
    end

    assign level = stable_q;
    assign rise  = stable_q & ~prev_q;
    assign fall  = ~stable_q & prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (rise & $past(rise)) == '0) else $error("rise held two cycles"); // R5
    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (fall & $past(fall)) == '0) else $error("fall held two cycles"); // R5
endmodule

// File: rtl/gpio_trig_eval.sv
module gpio_trig_eval
    import gpio_irq_pkg::*;
#(
    parameter int PINS    = 32,
    parameter bit ALT_MAP = 1'b0
) (
    input  logic [PINS-1:0] cfg_lo,
    input  logic [PINS-1:0] cfg_hi,
    input  logic [PINS-1:0] level,
    input  logic [PINS-1:0] rise,
    input  logic [PINS-1:0] fall,
    output logic [PINS-1:0] hit
);
    localparam int HALF = PINS / 2;

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        logic [1:0] code;
        trig_e      kind;
        logic       h;

        if (p < HALF) begin : g_lo
            assign code = cfg_lo[2*p +: 2];
        end else begin : g_hi
            assign code = cfg_hi[2*(p-HALF) +: 2];
        end

        assign kind = map_code(ALT_MAP, code);

        always_comb begin
            case (kind)
                TRIG_LOW:  h = ~level[p];
                TRIG_HIGH: h = level[p];
                TRIG_RISE: h = rise[p];
                default:   h = fall[p];
            endcase
        end

        assign hit[p] = h;
    end
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
    import gpio_irq_pkg::*;
#(
    parameter int PINS    = 32,
    parameter bit ALT_MAP = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFFS_W-1:0] addr,
    input  logic [PINS-1:0]   wdata,
    input  logic [PINS-1:0]   hit,
    input  logic [PINS-1:0]   level,
    output logic [PINS-1:0]   rdata,
    output logic [PINS-1:0]   value_q,
    output logic [PINS-1:0]   enable_q,
    output logic [PINS-1:0]   cfg_lo_q,
    output logic [PINS-1:0]   cfg_hi_q,
    output logic [PINS-1:0]   gate_q,
    output logic [PINS-1:0]   event_q
);
    localparam layout_t MAP = layout_for(ALT_MAP);

    reg_sel_e        sel;
    logic [PINS-1:0] clr;

    assign sel = decode_offset(addr, MAP);
    assign clr = (wr_en && sel == SEL_EVENT) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q  <= '0;
            enable_q <= '0;
            cfg_lo_q <= '0;
            cfg_hi_q <= '0;
            gate_q   <= '0;
            event_q  <= '0;
        end else begin
            if (wr_en) begin
                case (sel)
                    SEL_VALUE:  value_q  <= wdata;
                    SEL_ENABLE: enable_q <= wdata;
                    SEL_CFG_LO: cfg_lo_q <= wdata;
                    SEL_CFG_HI: cfg_hi_q <= wdata;
                    SEL_GATE:   gate_q   <= wdata;
                    default:    ;
                endcase
            end
            event_q <= (event_q & ~clr) | hit;
        end
    end

    always_comb begin
        case (sel)
            SEL_VALUE:  rdata = value_q;
            SEL_ENABLE: rdata = enable_q;
            SEL_LEVEL:  rdata = level;
            SEL_CFG_LO: rdata = cfg_lo_q;
            SEL_CFG_HI: rdata = cfg_hi_q;
            SEL_GATE:   rdata = gate_q;
            SEL_EVENT:  rdata = event_q;
            default:    rdata = '0;
        endcase
    end

    AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(event_q & ~clr) & ~event_q) == '0)) else $error("event bit lost"); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(hit) & ~event_q) == '0)) else $error("hit not latched"); // R6
    AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_ENABLE) |=> (enable_q == $past(wdata))) else $error("enable write lost"); // R2
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int PINS    = 32,
    parameter bit ALT_MAP = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [OFFS_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic              irq_lo,
    output logic              irq_hi,
    output logic              irq_any
);
    localparam int HALF = PINS / 2;

    logic [PINS-1:0] level, rise, fall, hit;
    logic [PINS-1:0] cfg_lo_q, cfg_hi_q, gate_q, event_q;
    logic [PINS-1:0] pending;

    gpio_pad_sync #(.WIDTH(PINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pad_in (pad_in),
        .level  (level),
        .rise   (rise),
        .fall   (fall)
    );

    gpio_trig_eval #(.PINS(PINS), .ALT_MAP(ALT_MAP)) u_trig (
        .cfg_lo (cfg_lo_q),
        .cfg_hi (cfg_hi_q),
        .level  (level),
        .rise   (rise),
        .fall   (fall),
        .hit    (hit)
    );

    gpio_reg_bank #(.PINS(PINS), .ALT_MAP(ALT_MAP)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .hit      (hit),
        .level    (level),
        .rdata    (bus_rdata),
        .value_q  (pad_out),
        .enable_q (pad_oe),
        .cfg_lo_q (cfg_lo_q),
        .cfg_hi_q (cfg_hi_q),
        .gate_q   (gate_q),
        .event_q  (event_q)
    );

    assign pending = event_q & gate_q;
    assign irq_lo  = |pending[HALF-1:0];
    assign irq_hi  = |pending[PINS-1:HALF];
    assign irq_any = irq_lo | irq_hi;

    AST_GATE_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (gate_q == '0) |-> !irq_any) else $error("irq with gate closed"); // R8
    AST_LOW_PIN_IRQ: assert property (@(posedge clk) disable iff (rst)
        (event_q[0] && gate_q[0]) |-> irq_lo) else $error("pin 0 not on low line"); // R8
    AST_HIGH_PIN_IRQ: assert property (@(posedge clk) disable iff (rst)
        (event_q[PINS-1] && gate_q[PINS-1]) |-> irq_hi) else $error("top pin not on high line"); // R8
endmodule

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        b_wr = 1'b0;
    logic [7:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] b_rdata;
    logic [31:0] b_pad = '0;
    logic [31:0] b_pout, b_poe;
    logic        b_lo, b_hi, b_any;

    logic        a_wr = 1'b0;
    logic [7:0]  a_addr = '0;
    logic [31:0] a_wdata = '0;
    logic [31:0] a_rdata;
    logic [31:0] a_pad = '0;
    logic [31:0] a_pout, a_poe;
    logic        a_lo, a_hi, a_any;

    int checks = 0;
    int failures = 0;
    bit pend = 1'b0;
    bit done = 1'b0;

    int          src_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_port #(.PINS(32), .ALT_MAP(1'b0)) uut (
        .clk(clk), .rst(rst), .bus_wr(b_wr), .bus_addr(b_addr), .bus_wdata(b_wdata),
        .bus_rdata(b_rdata), .pad_in(b_pad), .pad_out(b_pout), .pad_oe(b_poe),
        .irq_lo(b_lo), .irq_hi(b_hi), .irq_any(b_any)
    );

    gpio_irq_port #(.PINS(32), .ALT_MAP(1'b1)) uut_alt (
        .clk(clk), .rst(rst), .bus_wr(a_wr), .bus_addr(a_addr), .bus_wdata(a_wdata),
        .bus_rdata(a_rdata), .pad_in(a_pad), .pad_out(a_pout), .pad_oe(a_poe),
        .irq_lo(a_lo), .irq_hi(a_hi), .irq_any(a_any)
    );

    // Monitor: drains the scoreboard away from the active edge
    always @(negedge clk) begin
        if (pend) begin
            while (src_q.size() > 0) begin
                int          s;
                logic [31:0] e, act;
                string       t;
                s = src_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                case (s)
                    0:       act = b_rdata;
                    1:       act = {29'b0, b_any, b_hi, b_lo};
                    2:       act = b_pout;
                    3:       act = b_poe;
                    default: act = a_rdata;
                endcase
                checks++;
                if (act !== e) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", t, act, e);
                end
            end
        end
    end

    task automatic push(input int s, input logic [31:0] e, input string t);
        src_q.push_back(s);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic commit();
        pend = 1'b1;
        @(negedge clk);
        #1;
        pend = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input bit alt, input logic [7:0] a, input logic [31:0] d);
        @(posedge clk);
        #1;
        if (alt) begin a_wr = 1'b1; a_addr = a; a_wdata = d; end
        else     begin b_wr = 1'b1; b_addr = a; b_wdata = d; end
        @(posedge clk);
        #1;
        a_wr = 1'b0;
        b_wr = 1'b0;
    endtask

    task automatic rd(input bit alt, input logic [7:0] a, input logic [31:0] e, input string t);
        if (alt) begin a_addr = a; push(4, e, t); end
        else     begin b_addr = a; push(0, e, t); end
        commit();
    endtask

    task automatic irq_is(input logic [2:0] e, input string t);
        push(1, {29'b0, e}, t);
        commit();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(3);
        // R1: state while reset is held
        b_addr = 8'h18; push(0, 32'h0, "R1 event in reset"); commit();
        b_addr = 8'h00; push(0, 32'h0, "R1 value in reset");
        push(1, 32'h0, "R1 irq in reset");
        push(2, 32'h0, "R1 pad_out in reset");
        push(3, 32'h0, "R1 pad_oe in reset");
        commit();
        rst = 1'b0;
        step(2);
        // R4/R6: default code 0 is low level, pads are low
        rd(0, 8'h18, 32'hFFFF_FFFF, "R4 low level code 0 sets all");
        // R2
        wr(0, 8'h00, 32'hA5A5_0F0F);
        wr(0, 8'h04, 32'hFFFF_0000);
        push(2, 32'hA5A5_0F0F, "R2 pad_out");
        push(3, 32'hFFFF_0000, "R2 pad_oe");
        commit();
        rd(0, 8'h04, 32'hFFFF_0000, "R2 enable readback");
        rd(0, 8'h00, 32'hA5A5_0F0F, "R2 value readback");
        // R3: two-edge latency, level regardless of direction
        b_pad = 32'h1234_5678;
        step(1);
        rd(0, 8'h08, 32'h0, "R3 level after one edge");
        step(1);
        rd(0, 8'h08, 32'h1234_5678, "R3 level after two edges");
        // all pins rising edge
        wr(0, 8'h0C, 32'hAAAA_AAAA);
        wr(0, 8'h10, 32'hAAAA_AAAA);
        wr(0, 8'h18, 32'hFFFF_FFFF);
        rd(0, 8'h18, 32'h0, "R7 clear all");
        // R5: bit0 rises, bit3 falls, bit31 rises
        b_pad = 32'h9234_5671;
        step(3);
        rd(0, 8'h18, 32'h8000_0001, "R5 rising only");
        irq_is(3'b000, "R8 gate zero");
        // R8: split lines
        wr(0, 8'h14, 32'h0000_0001);
        irq_is(3'b101, "R8 low half");
        wr(0, 8'h14, 32'h8000_0000);
        irq_is(3'b110, "R8 high half");
        wr(0, 8'h14, 32'h0);
        irq_is(3'b000, "R8 gate cleared");
        // R7: zeros keep, ones clear
        wr(0, 8'h18, 32'h0);
        rd(0, 8'h18, 32'h8000_0001, "R7 zero write");
        wr(0, 8'h18, 32'h0000_0001);
        rd(0, 8'h18, 32'h8000_0000, "R7 partial clear");
        // R4: pin 4 falling edge in field bits 9:8
        wr(0, 8'h0C, 32'hAAAA_ABAA);
        wr(0, 8'h18, 32'hFFFF_FFFF);
        rd(0, 8'h18, 32'h0, "R7 clear again");
        b_pad = 32'h9234_5661;
        step(3);
        rd(0, 8'h18, 32'h0000_0010, "R4 pin4 falling");
        // R6: pin 20 high level, clear while level present
        wr(0, 8'h10, 32'hAAAA_A9AA);
        wr(0, 8'h18, 32'hFFFF_FFFF);
        rd(0, 8'h18, 32'h0010_0000, "R6 set wins over clear");
        b_pad = 32'h9224_5661;
        step(3);
        wr(0, 8'h18, 32'hFFFF_FFFF);
        rd(0, 8'h18, 32'h0, "R6 clear after level gone");
        // R10
        rd(0, 8'h40, 32'h0, "R10 unused offset");
        // R9: alternate placement and codes
        rd(1, 8'h34, 32'h0, "R9 alt code 0 is rising");
        wr(1, 8'h00, 32'h0000_000F);
        rd(1, 8'h00, 32'h0000_000F, "R9 alt enable at 0x00");
        wr(1, 8'h1C, 32'h1234_5678);
        rd(1, 8'h1C, 32'h1234_5678, "R9 alt value at 0x1C");
        a_pad = 32'h0000_0004;
        step(3);
        rd(1, 8'h34, 32'h0000_0004, "R9 alt rising event");
        rd(1, 8'h24, 32'h0000_0004, "R9 alt level at 0x24");
        wr(1, 8'h28, 32'h0000_0003);
        step(1);
        rd(1, 8'h34, 32'h0000_0005, "R9 alt code 3 low level");
        rd(1, 8'h18, 32'h0, "R10 alt unused offset");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule